// File: doc/BRIEF.md
# Low-Side Switch Channel Control and Fault Latch Array

This block holds the per-channel control logic for an array of low-side power switch channels. For each channel it picks which source drives the gate: a dedicated parallel input pin, a serial-control bit held in a register, or a bit received over a fast serial bus. A second input can force a group of channels off. The block also turns a channel off when a short to battery is seen while it is on. Each channel has a two-bit diagnostic field, and a command clears all of these fields.

The fault sensing is analog and sits outside the block. It arrives here as per-channel flags. Each flag combination is first reduced to a two-bit code. That code must stay the same for a configurable number of clock edges before it is written into the diagnostic field. The fields are sticky: a recorded code can only be replaced by a more severe one, until a clear command resets it.

A channel shut down by a short to battery stays off until its current control source has been seen off for at least one clock edge. Turning the source on again then re-enables the gate. For a fixed subset of channels, the shutdown can be disabled through a per-channel enable input.

Top module: `lsw_chan_array`

## Requirements
- R1: For channels 0 to 15, `mux_par[i]=1` selects parallel control, and the gate of channel i follows `pin_in[i]`. The serial and bus inputs then have no effect on channel i.
- R2: For channels 0 to 15 with `mux_par[i]=0`, the gate follows `spi_on[i]` when `bus_sel=0` and `bus_in[i]` when `bus_sel=1`. Channels 16 and 17 always follow `spi_on[i]`, whatever `bus_sel` is.
- R3: While `stage_hold=1`, channels 8 to 15 are off. All other channels keep following their sources.
- R4: After `rst_n` is low, every diagnostic field reads 11, so all of `diag_o` is ones.
- R5: Channel i's code sits at `diag_o[2i+1:2i]`. The codes are: 11 no fault, 10 open load, 01 short to ground, 00 short to battery or overtemperature. When flags are raised together, 00 beats 01, and 01 beats 10.
- R6: A code is recorded only once it has been present at FILT_LEN (default 4) consecutive rising edges. The field changes at the FILT_LEN-th edge. A run that is shorter, or that changes code, starts the count again.
- R7: A recorded field is replaced only by a numerically lower (more severe) code. It holds its value after the fault flags drop.
- R8: `diag_clr=1` at a rising edge sets every field to 11 at that edge. The clear takes priority over a recording in the same cycle.
- R9: A short to battery that passes the filter while a channel's gate is on turns that gate off from the same edge. The gate stays off while the controlling source stays on, even after the flag drops.
- R10: A tripped channel turns on again only after its current control source has been off at one rising edge and is then on. Toggling a source that does not control the channel has no effect.
- R11: For channels 8, 9 and 14 to 17, the trip of R9 happens only when `shut_en[i]=1`; the diagnostic code is still recorded. All other channels trip whatever `shut_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Parallel control pins, channels 0 to 15 |
| mux_par | input | 16 | Per-channel 1 = parallel pin control |
| bus_sel | input | 1 | 1 = fast bus drives serial-controlled channels 0 to 15 |
| bus_in | input | 16 | Latched fast-bus control bits |
| spi_on | input | 18 | Serial-control register bits |
| stage_hold | input | 1 | Forces channels 8 to 15 off |
| shut_en | input | 18 | Shutdown enable for configurable channels |
| flt_scb | input | 18 | Short-to-battery flags |
| flt_ot | input | 18 | Overtemperature flags |
| flt_scg | input | 18 | Short-to-ground flags |
| flt_ol | input | 18 | Open-load flags |
| diag_clr | input | 1 | Clears all diagnostic fields |
| gate_o | output | 18 | Gate enables |
| diag_o | output | 36 | Two-bit diagnostic field per channel |

## Verification
The bench covers the filter boundary, where a fault held for one edge fewer than FILT_LEN must leave the field at 11. A filter that is off by one would record it one edge early. It also checks a code change in mid-run, which a design that counts any fault continuously would record too soon. For trip release, it toggles a serial bit while the parallel pin controls the channel; a design that released on any source would wrongly turn the channel back on. It also checks that a clear wins over a fault that is still present, that the shutdown-enable bits are ignored on fixed channels, and that holding the group off leaves channels outside the group running.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    typedef enum logic [1:0] {
        DG_SHORT_BAT = 2'b00,
        DG_SHORT_GND = 2'b01,
        DG_OPEN      = 2'b10,
        DG_OK        = 2'b11
    } diag_code_e;
endpackage

// File: rtl/lsw_src_sel.sv
module lsw_src_sel (
    input  logic pin_i,
    input  logic par_i,
    input  logic bus_sel_i,
    input  logic bus_i,
    input  logic spi_i,
    output logic ctrl_o
);
    logic serial_bit;

    always_comb begin
        serial_bit = bus_sel_i ? bus_i : spi_i;
        ctrl_o     = par_i ? pin_i : serial_bit;
    end
endmodule

// File: rtl/lsw_fault_filt.sv
module lsw_fault_filt
    import lsw_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_scb_i,
    input  logic       flt_ot_i,
    input  logic       flt_scg_i,
    input  logic       flt_ol_i,
    input  logic       clr_i,
    output logic [1:0] diag_o,
    output logic       scb_qual_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FILT_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'((FILT_LEN > 1) ? 1 : 0);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        diag_code_e       last;
        diag_code_e       field;
    } filt_st_t;

    filt_st_t   st_d, st_q;
    diag_code_e raw;
    logic       qual;

    always_comb begin
        if (flt_scb_i || flt_ot_i)  raw = DG_SHORT_BAT;
        else if (flt_scg_i)         raw = DG_SHORT_GND;
        else if (flt_ol_i)          raw = DG_OPEN;
        else                        raw = DG_OK;

        st_d = st_q;
        qual = 1'b0;
        if (raw == DG_OK) begin
            st_d.cnt = '0;
        end else if (raw != st_q.last) begin
            st_d.cnt = CNT_FIRST;
            qual     = (FILT_LEN == 1);
        end else begin
            qual = (st_q.cnt >= CNT_MAX);
            if (!qual) st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.last = raw;

        if (clr_i)
            st_d.field = DG_OK;
        else if (qual && (2'(raw) < 2'(st_q.field)))
            st_d.field = raw;

        diag_o     = 2'(st_q.field);
        scb_qual_o = qual && flt_scb_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.last  <= DG_OK;
            st_q.field <= DG_OK;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (diag_o == 2'b11));

    // R7
    only_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (diag_o <= $past(diag_o)));
endmodule

// File: rtl/lsw_trip_latch.sv
module lsw_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_i,
    input  logic trip_i,
    input  logic hold_i,
    output logic gate_o
);
    typedef struct packed {
        logic tripped;
    } trip_st_t;

    trip_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.tripped)
            st_d.tripped = ctrl_i;
        else
            st_d.tripped = trip_i && ctrl_i && !hold_i;
        gate_o = ctrl_i && !st_q.tripped && !hold_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.tripped <= 1'b0;
        else        st_q         <= st_d;
    end

    // R9
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tripped |-> !gate_o);

    // R9
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tripped) |-> $past(trip_i));

    // R10
    release_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.tripped) |-> !$past(ctrl_i));

    // R3
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> !gate_o);
endmodule

// File: rtl/lsw_chan_array.sv
module lsw_chan_array #(
    parameter int NCH      = 18,
    parameter int NPAR     = 16,
    parameter int FILT_LEN = 4,
    parameter logic [NCH-1:0] SHUT_CFG_MASK = 18'h3C300,
    parameter logic [NCH-1:0] HOLD_MASK     = 18'h0FF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAR-1:0]   pin_in,
    input  logic [NPAR-1:0]   mux_par,
    input  logic              bus_sel,
    input  logic [NPAR-1:0]   bus_in,
    input  logic [NCH-1:0]    spi_on,
    input  logic              stage_hold,
    input  logic [NCH-1:0]    shut_en,
    input  logic [NCH-1:0]    flt_scb,
    input  logic [NCH-1:0]    flt_ot,
    input  logic [NCH-1:0]    flt_scg,
    input  logic [NCH-1:0]    flt_ol,
    input  logic              diag_clr,
    output logic [NCH-1:0]    gate_o,
    output logic [2*NCH-1:0]  diag_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ctrl;
        logic scb_qual;
        logic trip;

        if (i < NPAR) begin : g_par
            lsw_src_sel u_sel (
                .pin_i     (pin_in[i]),
                .par_i     (mux_par[i]),
                .bus_sel_i (bus_sel),
                .bus_i     (bus_in[i]),
                .spi_i     (spi_on[i]),
                .ctrl_o    (ctrl)
            );
        end else begin : g_ser
            assign ctrl = spi_on[i];
        end

        lsw_fault_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .flt_scb_i  (flt_scb[i]),
            .flt_ot_i   (flt_ot[i]),
            .flt_scg_i  (flt_scg[i]),
            .flt_ol_i   (flt_ol[i]),
            .clr_i      (diag_clr),
            .diag_o     (diag_o[2*i +: 2]),
            .scb_qual_o (scb_qual)
        );

        assign trip = scb_qual && (shut_en[i] || !SHUT_CFG_MASK[i]);

        lsw_trip_latch u_trip (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ctrl),
            .trip_i (trip),
            .hold_i (stage_hold && HOLD_MASK[i]),
            .gate_o (gate_o[i])
        );
    end

    // R3
    group_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_hold |-> ((gate_o & HOLD_MASK) == '0));

    // R4
    reset_diag_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (diag_o == '1));
endmodule

// File: tb/test_lsw_chan_array.sv
module test_lsw_chan_array;
    localparam int NCH  = 18;
    localparam int NPAR = 16;
    localparam int FL   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NPAR-1:0]   pin_in, mux_par, bus_in;
    logic              bus_sel, stage_hold, diag_clr;
    logic [NCH-1:0]    spi_on, shut_en, flt_scb, flt_ot, flt_scg, flt_ol;
    logic [NCH-1:0]    gate_o;
    logic [2*NCH-1:0]  diag_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lsw_chan_array #(.NCH(NCH), .NPAR(NPAR), .FILT_LEN(FL)) i_lsw_chan_array (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mux_par(mux_par),
        .bus_sel(bus_sel), .bus_in(bus_in), .spi_on(spi_on),
        .stage_hold(stage_hold), .shut_en(shut_en), .flt_scb(flt_scb),
        .flt_ot(flt_ot), .flt_scg(flt_scg), .flt_ol(flt_ol),
        .diag_clr(diag_clr), .gate_o(gate_o), .diag_o(diag_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] dg(input int ch);
        return diag_o[2*ch +: 2];
    endfunction

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pin_in = '0; mux_par = '0; bus_in = '0; bus_sel = 1'b0;
        spi_on = '0; stage_hold = 1'b0; shut_en = '0; flt_scb = '0; flt_ot = '0;
        flt_scg = '0; flt_ol = '0; diag_clr = 1'b0;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        chk("R4 diag after reset", 64'(diag_o), 64'(36'hF_FFFF_FFFF));
        chk("R4 gates off after reset", 64'(gate_o), 64'h0);
    endtask

    task automatic t_source;
        mux_par = 16'h00FF; pin_in = 16'h00A5; spi_on = 18'h2_C300; bus_sel = 1'b0;
        bus_in = 16'hFFFF;
        #1 chk("R1 R2 pin and spi mix", 64'(gate_o), 64'(18'h2_C3A5));
        bus_sel = 1'b1; bus_in = 16'h3C00;
        #1 chk("R2 bus drives serial channels, 16/17 stay spi", 64'(gate_o), 64'(18'h2_3CA5));
        pin_in = 16'hFF5A;
        #1 chk("R1 pins ignored on serial channels", 64'(gate_o), 64'(18'h2_3C5A));
        spi_on = 18'h1_00FF;
        #1 chk("R1 spi ignored on parallel channels", 64'(gate_o), 64'(18'h1_3C5A));
        edges(1);
        mux_par = '0; pin_in = '0; bus_sel = 1'b0; bus_in = '0; spi_on = '0;
        edges(1);
    endtask

    task automatic t_hold;
        spi_on = '1; stage_hold = 1'b1;
        #1 chk("R3 group forced off", 64'(gate_o), 64'(18'h3_00FF));
        edges(2);
        chk("R3 group still off", 64'(gate_o), 64'(18'h3_00FF));
        stage_hold = 1'b0;
        #1 chk("R3 group back on", 64'(gate_o), 64'(18'h3_FFFF));
        spi_on = '0;
        edges(1);
    endtask

    task automatic t_filter;
        flt_scg[3] = 1'b1;
        edges(FL - 1);
        chk("R6 not yet recorded ch3", 64'(dg(3)), 64'(2'b11));
        edges(1);
        chk("R6 R5 short-to-ground ch3", 64'(dg(3)), 64'(2'b01));
        flt_ol[4] = 1'b1;
        edges(FL - 1);
        flt_ol[4] = 1'b0;
        edges(FL);
        chk("R6 short run ignored ch4", 64'(dg(4)), 64'(2'b11));
        flt_ol[6] = 1'b1;
        edges(2);
        flt_ol[6] = 1'b0; flt_scg[6] = 1'b1;
        edges(2);
        chk("R6 code change restarts ch6", 64'(dg(6)), 64'(2'b11));
        edges(2);
        chk("R6 new code recorded ch6", 64'(dg(6)), 64'(2'b01));
        flt_scg[6] = 1'b0;
        flt_scg[5] = 1'b1; flt_ol[5] = 1'b1;
        edges(FL);
        chk("R5 ground beats open ch5", 64'(dg(5)), 64'(2'b01));
        flt_ot[5] = 1'b1;
        edges(FL);
        chk("R5 overtemp gives 00 ch5", 64'(dg(5)), 64'(2'b00));
        flt_ot[5] = 1'b0; flt_scg[5] = 1'b0; flt_ol[5] = 1'b0;
        flt_scg[3] = 1'b0; flt_ol[3] = 1'b1;
        edges(FL + 2);
        chk("R7 sticky after flags drop ch5", 64'(dg(5)), 64'(2'b00));
        chk("R7 milder code ignored ch3", 64'(dg(3)), 64'(2'b01));
        flt_ol[3] = 1'b0;
        diag_clr = 1'b1;
        edges(1);
        diag_clr = 1'b0;
        chk("R8 clear all fields", 64'(diag_o), 64'(36'hF_FFFF_FFFF));
        flt_ol[7] = 1'b1;
        edges(FL);
        chk("R5 open load ch7", 64'(dg(7)), 64'(2'b10));
        diag_clr = 1'b1;
        edges(1);
        diag_clr = 1'b0;
        chk("R8 clear wins over live fault ch7", 64'(dg(7)), 64'(2'b11));
        edges(1);
        chk("R6 live fault recorded again ch7", 64'(dg(7)), 64'(2'b10));
        flt_ol[7] = 1'b0;
        diag_clr = 1'b1;
        edges(1);
        diag_clr = 1'b0;
    endtask

    task automatic t_trip;
        spi_on[2] = 1'b1;
        #1 chk("R2 ch2 on", 64'(gate_o[2]), 64'h1);
        flt_scb[2] = 1'b1;
        edges(FL - 1);
        chk("R9 ch2 still on before filter", 64'(gate_o[2]), 64'h1);
        edges(1);
        chk("R9 ch2 tripped", 64'(gate_o[2]), 64'h0);
        chk("R5 ch2 short-to-battery code", 64'(dg(2)), 64'(2'b00));
        flt_scb[2] = 1'b0;
        edges(3);
        chk("R9 ch2 stays off with source on", 64'(gate_o[2]), 64'h0);
        spi_on[2] = 1'b0;
        edges(1);
        spi_on[2] = 1'b1;
        #1 chk("R10 ch2 back on after off/on", 64'(gate_o[2]), 64'h1);
        mux_par[1] = 1'b1; pin_in[1] = 1'b1; flt_scb[1] = 1'b1;
        edges(FL);
        chk("R9 ch1 parallel tripped", 64'(gate_o[1]), 64'h0);
        flt_scb[1] = 1'b0; spi_on[1] = 1'b0;
        edges(2);
        spi_on[1] = 1'b1;
        edges(1);
        chk("R10 spi toggle ignored on pin channel", 64'(gate_o[1]), 64'h0);
        pin_in[1] = 1'b0;
        edges(1);
        pin_in[1] = 1'b1;
        #1 chk("R10 ch1 back on after pin cycle", 64'(gate_o[1]), 64'h1);
        edges(1);
        spi_on = '0; pin_in = '0; mux_par = '0;
        edges(1);
    endtask

    task automatic t_cfg;
        spi_on = 18'h1_0301; shut_en = 18'h0_0200;
        flt_scb = 18'h1_0301;
        edges(FL + 1);
        chk("R11 config channels 8 and 16 stay on, 9 and 0 trip",
            64'(gate_o), 64'(18'h1_0100));
        chk("R11 ch8 code still recorded", 64'(dg(8)), 64'(2'b00));
        chk("R11 ch16 code still recorded", 64'(dg(16)), 64'(2'b00));
        flt_scb = '0;
        spi_on = '0;
        edges(1);
        spi_on = 18'h1_0301;
        #1 chk("R10 all back on", 64'(gate_o), 64'(18'h1_0301));
    endtask

    initial begin
        t_reset();
        t_source();
        t_hold();
        t_filter();
        t_trip();
        t_cfg();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule